// File: doc/BRIEF.md
# Partial-Width Aliased Register File

This block is a bank of general-purpose registers in which each register can be updated at several widths. A write replaces the whole register, only its low half, or, on the first few registers, one of the two bytes that make up that low half. Bits outside the written part always keep their value, so a narrow write merges into the register rather than clearing it.

There is one clocked write port. It takes a register index, a two-bit part code and the write data. There are two independent combinational read ports, each with its own index and part code. A read returns the selected part moved down to bit 0 and zero-extended to the full register width.

A high-byte access that names a register without a high-byte alias is illegal. Such a write is discarded, and an error output flags it in the same cycle.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous active-high reset sets every register to zero.
- R2: Part code 11 (doubleword) with the write enable high replaces all 32 bits of the indexed register with the write data.
- R3: Part code 10 (word) loads bits 15:0 of the register from write data bits 15:0 and keeps bits 31:16.
- R4: Part code 00 (low byte) loads bits 7:0 of the register from write data bits 7:0 and keeps bits 31:8.
- R5: Part code 01 (high byte) on registers 0 to 3 loads bits 15:8 of the register from write data bits 7:0 and keeps every other bit.
- R6: A part-01 write that names registers 4 to 7 changes no register and drives the error output high in that same cycle.
- R7: The error output is low whenever the write enable is low or the write is legal.
- R8: A read with part 00 returns bits 7:0, part 01 returns bits 15:8, part 10 returns bits 15:0 and part 11 returns all 32 bits. The selected field sits at bit 0 and all bits above it are zero.
- R9: A part-01 read of registers 4 to 7 returns zero.
- R10: The two read ports work independently. A read of the register being written in that cycle returns the value from before the write.
- R11: With the write enable low, no register changes, whatever the index, part code and data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Register written |
| wr_part | input | 2 | Part written (00 low byte, 01 high byte, 10 word, 11 doubleword) |
| wr_data | input | 32 | Write data, taken from bit 0 upward |
| wr_err | output | 1 | Illegal high-byte write in this cycle |
| rd0_idx | input | 3 | Read port 0 register |
| rd0_part | input | 2 | Read port 0 part code |
| rd0_data | output | 32 | Read port 0 zero-extended result |
| rd1_idx | input | 3 | Read port 1 register |
| rd1_part | input | 2 | Read port 1 part code |
| rd1_data | output | 32 | Read port 1 zero-extended result |

## Verification
The bench builds the block with its default parameters: eight registers of 32 bits, 8-bit bytes, and a high-byte alias on the first four registers. With a 3-bit index, these values put both halves of the register range within reach. Legal high-byte writes on registers 0 to 3 and illegal ones on registers 4 to 7 are therefore both exercised, each against a shadow model. After every write, the bench reads back every register at all four part codes, so a merge that disturbs a neighbouring field or another register is caught.

// File: rtl/alias_regfile_pkg.sv
`timescale 1ns/1ps
package alias_regfile_pkg;
  typedef enum logic [1:0] {
    PART_LO    = 2'b00,
    PART_HI    = 2'b01,
    PART_WORD  = 2'b10,
    PART_DWORD = 2'b11
  } part_e;
endpackage

// File: rtl/ar_write_merge.sv
`timescale 1ns/1ps
// Merges narrow write data into the current register value (R2..R5).
module ar_write_merge
  import alias_regfile_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic [REG_W-1:0] old_val,
  input  part_e            part,
  input  logic [REG_W-1:0] data,
  output logic [REG_W-1:0] new_val
);
  localparam int HALF_W = 2 * BYTE_W;

  always_comb begin
    new_val = old_val;
    case (part)
      PART_LO:   new_val[BYTE_W-1:0]      = data[BYTE_W-1:0];
      PART_HI:   new_val[HALF_W-1:BYTE_W] = data[BYTE_W-1:0];
      PART_WORD: new_val[HALF_W-1:0]      = data[HALF_W-1:0];
      default:   new_val                  = data;
    endcase
  end
endmodule

// File: rtl/ar_read_extract.sv
`timescale 1ns/1ps
// Selects one register part and zero-extends it (R8, R9).
module ar_read_extract
  import alias_regfile_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int HI_REGS  = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  input  logic [IDX_W-1:0]               idx,
  input  part_e                          part,
  output logic [REG_W-1:0]               data
);
  localparam int HALF_W = 2 * BYTE_W;

  logic [REG_W-1:0] sel;
  logic             hi_ok;

  assign sel   = regs[idx];
  assign hi_ok = (int'(idx) < HI_REGS);

  always_comb begin
    data = '0;
    case (part)
      PART_LO:   data[BYTE_W-1:0] = sel[BYTE_W-1:0];
      PART_HI:   data[BYTE_W-1:0] = hi_ok ? sel[HALF_W-1:BYTE_W] : '0;
      PART_WORD: data[HALF_W-1:0] = sel[HALF_W-1:0];
      default:   data             = sel;
    endcase
  end
endmodule

// File: rtl/alias_regfile.sv
`timescale 1ns/1ps
module alias_regfile
  import alias_regfile_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int HI_REGS  = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_part,
  input  logic [REG_W-1:0] wr_data,
  output logic             wr_err,
  input  logic [IDX_W-1:0] rd0_idx,
  input  logic [1:0]       rd0_part,
  output logic [REG_W-1:0] rd0_data,
  input  logic [IDX_W-1:0] rd1_idx,
  input  logic [1:0]       rd1_part,
  output logic [REG_W-1:0] rd1_data
);
  localparam int HALF_W = 2 * BYTE_W;
  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [NUM_REGS-1:0]            wen;
  logic [REG_W-1:0]               merged;
  part_e                          wpart;
  logic                           hi_bad;

  assign wpart  = part_e'(wr_part);
  assign hi_bad = (wpart == PART_HI) && !(int'(wr_idx) < HI_REGS);
  assign wr_err = wr_en && hi_bad;

  ar_write_merge #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_merge (
    .old_val (regs_q[wr_idx]),
    .part    (wpart),
    .data    (wr_data),
    .new_val (merged)
  );

  // Per-register write enable; a register without a high-byte alias
  // ignores a high-byte write.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wen
    localparam bit HAS_HI = (i < HI_REGS);
    if (HAS_HI) begin : g_full
      assign wen[i] = wr_en && (int'(wr_idx) == i);
    end else begin : g_nohi
      assign wen[i] = wr_en && (int'(wr_idx) == i) && (wpart != PART_HI);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wen[i]) regs_q[i] <= merged;
      end
    end
  end

  // Read ports
  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx_a;
  logic [NUM_RD-1:0][1:0]       rd_part_a;
  logic [NUM_RD-1:0][REG_W-1:0] rd_data_a;

  assign rd_idx_a  = {rd1_idx, rd0_idx};
  assign rd_part_a = {rd1_part, rd0_part};
  assign rd0_data  = rd_data_a[0];
  assign rd1_data  = rd_data_a[1];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    ar_read_extract #(
      .REG_W(REG_W), .BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS),
      .HI_REGS(HI_REGS), .IDX_W(IDX_W)
    ) u_rd (
      .regs (regs_q),
      .idx  (rd_idx_a[p]),
      .part (part_e'(rd_part_a[p])),
      .data (rd_data_a[p])
    );
  end

  // Assertions
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (regs_q == '0));

  assert_dword_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wpart == PART_DWORD) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

  assert_word_keeps_top_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wpart == PART_WORD) |=>
      (regs_q[$past(wr_idx)][REG_W-1:HALF_W] == $past(regs_q[wr_idx][REG_W-1:HALF_W])));

  assert_lo_keeps_rest_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wpart == PART_LO) |=>
      (regs_q[$past(wr_idx)][REG_W-1:BYTE_W] == $past(regs_q[wr_idx][REG_W-1:BYTE_W])));

  assert_illegal_hi_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> $stable(regs_q));

  assert_err_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> (wr_en && wpart == PART_HI));

  assert_idle_no_change_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_q));

  assert_read_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
    (rd0_part != 2'b11) |-> (rd0_data[REG_W-1:HALF_W] == '0));

  assert_hi_read_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd1_part == 2'b01 && !(int'(rd1_idx) < HI_REGS)) |-> (rd1_data == '0));
endmodule

// File: tb/alias_regfile_test.sv
`timescale 1ns/1ps
module alias_regfile_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_part;
  logic [31:0] wr_data;
  logic        wr_err;
  logic [2:0]  rd0_idx, rd1_idx;
  logic [1:0]  rd0_part, rd1_part;
  logic [31:0] rd0_data, rd1_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  alias_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part),
    .wr_data(wr_data), .wr_err(wr_err),
    .rd0_idx(rd0_idx), .rd0_part(rd0_part), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_part(rd1_part), .rd1_data(rd1_data)
  );

  logic [31:0] shadow [8];

  // {idx[3], part[2], data[32], expected_err[1]}
  localparam int NV = 16;
  localparam logic [37:0] VEC [NV] = '{
    {3'd0, 2'b11, 32'h11223344, 1'b0},
    {3'd0, 2'b00, 32'hFFFFFFAA, 1'b0},
    {3'd0, 2'b01, 32'h000000BB, 1'b0},
    {3'd0, 2'b10, 32'h5555CAFE, 1'b0},
    {3'd1, 2'b11, 32'hDEADBEEF, 1'b0},
    {3'd1, 2'b01, 32'h12345677, 1'b0},
    {3'd2, 2'b00, 32'hFFFFFF5A, 1'b0},
    {3'd3, 2'b10, 32'h9999ABCD, 1'b0},
    {3'd4, 2'b11, 32'hA5A5A5A5, 1'b0},
    {3'd4, 2'b01, 32'h000000FF, 1'b1},
    {3'd7, 2'b01, 32'h00000011, 1'b1},
    {3'd5, 2'b10, 32'h00001234, 1'b0},
    {3'd7, 2'b11, 32'hFFFFFFFF, 1'b0},
    {3'd7, 2'b00, 32'h00000000, 1'b0},
    {3'd6, 2'b00, 32'h00000042, 1'b0},
    {3'd3, 2'b01, 32'h00000000, 1'b0}
  };

  function automatic logic [31:0] merge(logic [31:0] o, logic [1:0] p, logic [31:0] d);
    case (p)
      2'b00:   return {o[31:8], d[7:0]};
      2'b01:   return {o[31:16], d[7:0], o[7:0]};
      2'b10:   return {o[31:16], d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] expect_rd(int r, logic [1:0] p);
    case (p)
      2'b00:   return {24'h0, shadow[r][7:0]};
      2'b01:   return (r < 4) ? {24'h0, shadow[r][15:8]} : 32'h0;
      2'b10:   return {16'h0, shadow[r][15:0]};
      default: return shadow[r];
    endcase
  endfunction

  function automatic string req_of(logic [1:0] p);
    case (p)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read every register at every part code and compare with the shadow
  task automatic sweep(string req);
    for (int r = 0; r < 8; r++) begin
      for (int p = 0; p < 4; p++) begin
        rd0_idx = 3'(r); rd0_part = 2'b11;
        rd1_idx = 3'(r); rd1_part = 2'(p);
        #1;
        chk(req, rd0_data, shadow[r]);
        chk((p == 1 && r >= 4) ? "R9" : "R8", rd1_data, expect_rd(r, 2'(p)));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_part = '0; wr_data = '0;
    rd0_idx = '0; rd0_part = '0; rd1_idx = '0; rd1_part = '0;
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    sweep("R1");

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en   = 1'b1;
      wr_idx  = VEC[v][37:35];
      wr_part = VEC[v][34:33];
      wr_data = VEC[v][32:1];
      rd0_idx = wr_idx; rd0_part = 2'b11;
      rd1_idx = wr_idx; rd1_part = 2'b11;
      #1;
      chk(VEC[v][0] ? "R6" : "R7", {31'h0, wr_err}, {31'h0, VEC[v][0]});
      chk("R10", rd0_data, shadow[wr_idx]);
      @(posedge clk);
      if (!VEC[v][0]) shadow[wr_idx] = merge(shadow[wr_idx], wr_part, wr_data);
      @(negedge clk);
      wr_en = 1'b0;
      sweep(VEC[v][0] ? "R6" : req_of(VEC[v][34:33]));
    end

    // R11 / R7: enable low with an illegal-looking request
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 3'd6; wr_part = 2'b01; wr_data = 32'hFFFFFFFF;
    #1;
    chk("R7", {31'h0, wr_err}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    wr_idx = 3'd0; wr_part = 2'b11; wr_data = 32'h0BADF00D;
    @(posedge clk);
    @(negedge clk);
    sweep("R11");

    // R10: both ports on different registers while port 0 register is written
    wr_en = 1'b1; wr_idx = 3'd2; wr_part = 2'b11; wr_data = 32'h13579BDF;
    rd0_idx = 3'd2; rd0_part = 2'b00; rd1_idx = 3'd1; rd1_part = 2'b01;
    #1;
    chk("R10", rd0_data, {24'h0, shadow[2][7:0]});
    chk("R10", rd1_data, {24'h0, shadow[1][15:8]});
    @(posedge clk);
    shadow[2] = 32'h13579BDF;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R10", rd0_data, 32'h000000DF);

    // R1: reset in mid-run clears everything
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    sweep("R1");

    finish_run();
  end
endmodule